// File: doc/BRIEF.md
# Flag Offset Register Bank

This block holds the two thresholds used by a two-clock FIFO's partial status flags: the almost-empty threshold `n` and the almost-full threshold `m`. Each threshold is kept as a low byte and a high part, which gives four small registers. Software or a controller on the FIFO's write side loads them one byte at a time from the write data bus. A controller on the read side reads them back, one at a time, onto the read data bus. There is no address input. A single rotating pointer picks the next register in this fixed order: empty low byte, empty high part, full low byte, full high part, then the empty low byte again. The pointer keeps its position between load sessions, and reads and writes move the same pointer.

The bank only works when the FIFO was put into programmable-threshold mode at reset. The mode is chosen by holding the load strobe low while reset is active. If the strobe is high during reset, the bank stays idle and both thresholds remain at their default value of 7. While a load session is open (the load strobe is low in programmable mode), the block raises hold outputs in each clock domain so that the FIFO's normal data path does not move its pointers.

The read side is a valid/ready stream:
- A request (both read enables low while loading) is accepted only on a read-clock edge where `rd_ready` is high.
- The accepted byte appears on `rd_data`, with `rd_data_valid` high for one cycle.
- `rd_ready` then stays low until the pointer advance has gone through the write domain and come back. A requester that keeps its enables low simply waits.
- The write side has no back-pressure. Every qualified write-clock edge is accepted.

Top module: `flag_offset_bank`

## Requirements
- R1: The mode is sampled on write-clock and read-clock edges while `rst_n` is low. If `load_n` is low, the bank is in programmable mode. Otherwise load and read strobes are ignored: both offsets stay at 7, `rd_data_valid` never rises, and both hold outputs stay low.
- R2: Reset sets both low-byte registers to 7, both high-part registers to 0 and the pointer to slot 0. After reset, `n_ofs` = `m_ofs` = 7, `rd_data` = 0, `rd_data_valid` = 0 and `rd_ready` = 1.
- R3: In programmable mode, each write-clock edge with `load_n` = 0 and `wr_en_n` = 0 stores `wr_data` into the slot under the pointer and advances the pointer. The slots are 0 = empty low byte, 1 = empty high part, 2 = full low byte, 3 = full high part. After slot 3 the pointer returns to slot 0.
- R4: The pointer is kept when `load_n` goes high and is not reset by a new session. Reads and writes advance the same pointer, so a session of either kind continues where the previous one stopped.
- R5: An accepted read puts the slot under the pointer on `rd_data` at the accepting read-clock edge, with `rd_data_valid` high for exactly that cycle. The pointer then advances, so reads follow the same slot order as writes.
- R6: A high-part register is `DEPTH_LOG2`−8 bits wide. Write-data bits above that width are ignored. On readback, every `rd_data` bit above the register's width is 0.
- R7: `n_ofs` is {empty high part, empty low byte} and `m_ofs` is {full high part, full low byte}. Each is `DEPTH_LOG2` bits wide.
- R8: After an accepted read, `rd_ready` is low from the next cycle until the pointer advance is visible in the read domain. Requests made while `rd_ready` is low are not accepted.
- R9: `wr_hold` is high while the bank is in programmable mode and `load_n` is low. `rd_hold` follows the same rule, sampled in the read domain.
- R10: Both offsets change only on a write-clock edge that stores a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, held for several edges of both clocks |
| load_n | input | 1 | Load strobe, active low; its level during reset selects the mode |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 8 | Byte to store (write data bus) |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| rd_ready | output | 1 | The read side can accept a request |
| rd_data | output | DATA_W | Readback byte, zero-extended |
| rd_data_valid | output | 1 | `rd_data` was updated this cycle |
| n_ofs | output | DEPTH_LOG2 | Almost-empty threshold (write domain) |
| m_ofs | output | DEPTH_LOG2 | Almost-full threshold (write domain) |
| wr_hold | output | 1 | Suppresses FIFO writes during a load session |
| rd_hold | output | 1 | Suppresses FIFO reads during a load session |

## Verification
The properties assume that a session never writes and reads in the same period. They also assume that, after the last write of a session, enough read-clock cycles pass for the pointer and the register contents to cross domains before any read. Finally, they assume that `load_n` only changes while the enables are inactive. The stimulus meets these assumptions as follows:
- Each session is fully one kind, either all writes or all reads.
- Idle time is placed between a write session and a read session.
- `load_n` is only toggled at write-clock falling edges, with both enables high.
- During a burst, the read enables are held low so that back-pressure is exercised.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int LSB_W     = 8;
  localparam int NUM_SLOTS = 4;

  typedef logic [1:0] slot_t;

  // slot order is behaviour: bit1 selects full threshold, bit0 selects high part
  localparam slot_t SLOT_E_LO = 2'd0;
  localparam slot_t SLOT_E_HI = 2'd1;
  localparam slot_t SLOT_F_LO = 2'd2;
  localparam slot_t SLOT_F_HI = 2'd3;

  function automatic slot_t to_gray(slot_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic slot_t from_gray(slot_t g);
    return {g[1], g[1] ^ g[0]};
  endfunction
endpackage

// File: rtl/ofs_sync.sv
module ofs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ofs_mode_cap.sv
module ofs_mode_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  output logic prog
);
  // mode follows the strobe level while reset is held, then freezes
  always_ff @(posedge clk) begin
    if (!rst_n) prog <= ~load_n;
  end
endmodule

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
  import ofs_pkg::*;
#(
  parameter int DATA_W     = 9,
  parameter int DEPTH_LOG2 = 15,
  parameter int RESET_LSB  = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_fire,
  input  logic [LSB_W-1:0]               wr_data,
  input  logic                           adv_tgl,
  output slot_t                          sel_gray,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] view,
  output logic [DEPTH_LOG2-1:0]          n_ofs,
  output logic [DEPTH_LOG2-1:0]          m_ofs
);
  localparam int MSB_W = DEPTH_LOG2 - LSB_W;

  logic [1:0]       adv_sync;
  logic             adv_prev;
  logic             adv_pulse;
  slot_t            sel_q;
  logic [LSB_W-1:0] lo_q [2];
  logic [MSB_W-1:0] hi_q [2];

  ofs_sync #(.W(1)) u_adv_sync (
    .clk(clk), .rst_n(rst_n), .d(adv_tgl), .q(adv_sync[0])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_prev <= 1'b0;
    else        adv_prev <= adv_sync[0];
  end
  assign adv_sync[1] = adv_prev;
  assign adv_pulse   = adv_sync[0] ^ adv_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sel_q <= SLOT_E_LO;
    else if (wr_fire || adv_pulse)   sel_q <= sel_q + 2'd1;
  end
  assign sel_gray = to_gray(sel_q);

  for (genvar k = 0; k < 2; k++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[k] <= LSB_W'(RESET_LSB);
        hi_q[k] <= '0;
      end else if (wr_fire) begin
        if (sel_q == slot_t'({k[0], 1'b0})) lo_q[k] <= wr_data;
        if (sel_q == slot_t'({k[0], 1'b1})) hi_q[k] <= wr_data[MSB_W-1:0];
      end
    end
    assign view[2*k]     = DATA_W'(lo_q[k]);
    assign view[2*k + 1] = DATA_W'(hi_q[k]);
  end

  assign n_ofs = {hi_q[0], lo_q[0]};
  assign m_ofs = {hi_q[1], lo_q[1]};
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_req,
  input  slot_t                            sel_gray,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] view,
  output logic                             rd_ready,
  output logic [DATA_W-1:0]                rd_data,
  output logic                             rd_data_valid,
  output logic                             adv_tgl
);
  slot_t gray_s;
  slot_t sel_now;
  slot_t pend_q;
  logic  busy_q;
  logic  accept;

  ofs_sync #(.W(2)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d(sel_gray), .q(gray_s)
  );
  assign sel_now  = from_gray(gray_s);
  assign accept   = rd_req && !busy_q;
  assign rd_ready = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      pend_q        <= SLOT_E_LO;
      rd_data       <= '0;
      rd_data_valid <= 1'b0;
      adv_tgl       <= 1'b0;
    end else begin
      rd_data_valid <= accept;
      if (accept) begin
        rd_data <= view[sel_now];
        adv_tgl <= ~adv_tgl;
        busy_q  <= 1'b1;
        pend_q  <= sel_now;
      end else if (busy_q && sel_now != pend_q) begin
        busy_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flag_offset_bank.sv
module flag_offset_bank
  import ofs_pkg::*;
#(
  parameter int DATA_W     = 9,
  parameter int DEPTH_LOG2 = 15,
  parameter int RESET_LSB  = 7
) (
  input  logic                  wclk,
  input  logic                  rclk,
  input  logic                  rst_n,
  input  logic                  load_n,
  input  logic                  wr_en_n,
  input  logic [7:0]            wr_data,
  input  logic                  rd_en_a_n,
  input  logic                  rd_en_b_n,
  output logic                  rd_ready,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_data_valid,
  output logic [DEPTH_LOG2-1:0] n_ofs,
  output logic [DEPTH_LOG2-1:0] m_ofs,
  output logic                  wr_hold,
  output logic                  rd_hold
);
  logic                             prog_w;
  logic                             prog_r;
  logic                             wr_fire;
  logic                             rd_req;
  logic                             adv_tgl;
  slot_t                            sel_gray;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] view;

  ofs_mode_cap u_mode_w (.clk(wclk), .rst_n(rst_n), .load_n(load_n), .prog(prog_w));
  ofs_mode_cap u_mode_r (.clk(rclk), .rst_n(rst_n), .load_n(load_n), .prog(prog_r));

  assign wr_hold = prog_w & ~load_n;
  assign rd_hold = prog_r & ~load_n;
  assign wr_fire = wr_hold & ~wr_en_n;
  assign rd_req  = rd_hold & ~rd_en_a_n & ~rd_en_b_n;

  ofs_wr_bank #(
    .DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2), .RESET_LSB(RESET_LSB)
  ) u_wr (
    .clk(wclk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_data(wr_data),
    .adv_tgl(adv_tgl), .sel_gray(sel_gray), .view(view),
    .n_ofs(n_ofs), .m_ofs(m_ofs)
  );

  ofs_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk(rclk), .rst_n(rst_n), .rd_req(rd_req), .sel_gray(sel_gray),
    .view(view), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_data_valid(rd_data_valid), .adv_tgl(adv_tgl)
  );
endmodule

// File: rtl/ofs_bank_chk.sv
module ofs_bank_chk #(
  parameter int OFS_W     = 15,
  parameter int RESET_LSB = 7
) (
  input logic             wclk,
  input logic             rclk,
  input logic             rst_n,
  input logic             load_n,
  input logic             wr_en_n,
  input logic             rd_en_a_n,
  input logic             rd_en_b_n,
  input logic             rd_ready,
  input logic             rd_data_valid,
  input logic [OFS_W-1:0] n_ofs,
  input logic [OFS_W-1:0] m_ofs,
  input logic             prog_w
);
  assert_valid_follows_accept_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_data_valid |-> $past(!load_n && !rd_en_a_n && !rd_en_b_n && rd_ready));

  assert_valid_one_cycle_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_data_valid |=> !rd_data_valid);

  assert_busy_after_accept_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_data_valid |-> !rd_ready);

  assert_offsets_stable_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    !(!load_n && !wr_en_n) |=> ($stable(n_ofs) && $stable(m_ofs)));

  assert_inert_defaults_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    !prog_w |-> (n_ofs == OFS_W'(RESET_LSB) && m_ofs == OFS_W'(RESET_LSB)));
endmodule

bind flag_offset_bank ofs_bank_chk #(.OFS_W(DEPTH_LOG2), .RESET_LSB(RESET_LSB)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
  .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .rd_ready(rd_ready),
  .rd_data_valid(rd_data_valid), .n_ofs(n_ofs), .m_ofs(m_ofs), .prog_w(prog_w)
);

// File: tb/flag_offset_bank_bench.sv
module flag_offset_bank_bench;
  localparam int DATA_W = 9;
  localparam int DL2    = 15;
  localparam int MSB_W  = DL2 - 8;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic load_n = 0, wr_en_n = 1, rd_en_a_n = 1, rd_en_b_n = 1;
  logic [7:0] wr_data = '0;
  logic rd_ready, rd_data_valid, wr_hold, rd_hold;
  logic [DATA_W-1:0] rd_data;
  logic [DL2-1:0] n_ofs, m_ofs;

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] expq [$];
  logic [7:0]       mlo [2];
  logic [MSB_W-1:0] mhi [2];
  int msel;

  always #10 wclk = ~wclk;
  always #14 rclk = ~rclk;

  flag_offset_bank #(.DATA_W(DATA_W), .DEPTH_LOG2(DL2)) u_flag_offset_bank (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_data_valid(rd_data_valid),
    .n_ofs(n_ofs), .m_ofs(m_ofs), .wr_hold(wr_hold), .rd_hold(rd_hold)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] slot_val(int s);
    case (s)
      0: return DATA_W'(mlo[0]);
      1: return DATA_W'(mhi[0]);
      2: return DATA_W'(mlo[1]);
      default: return DATA_W'(mhi[1]);
    endcase
  endfunction

  function automatic logic [DL2-1:0] exp_n(); return {mhi[0], mlo[0]}; endfunction
  function automatic logic [DL2-1:0] exp_m(); return {mhi[1], mlo[1]}; endfunction

  task automatic model_reset();
    mlo[0] = 8'd7; mlo[1] = 8'd7; mhi[0] = '0; mhi[1] = '0; msel = 0;
  endtask

  task automatic do_reset(input logic mode_load_n);
    @(negedge wclk);
    rst_n = 0; load_n = mode_load_n; wr_en_n = 1; rd_en_a_n = 1; rd_en_b_n = 1;
    repeat (6) @(negedge rclk);
    @(negedge wclk); rst_n = 1; load_n = 1;
    model_reset();
    repeat (4) @(negedge wclk);
  endtask

  // driver: one store, model updated
  task automatic write_byte(input logic [7:0] v);
    @(negedge wclk); wr_en_n = 0; wr_data = v;
    @(negedge wclk); wr_en_n = 1;
    if (msel[0]) mhi[msel[1]] = v[MSB_W-1:0]; else mlo[msel[1]] = v;
    msel = (msel + 1) % 4;
  endtask

  // driver: burst of reads with enables held low across back-pressure
  task automatic read_burst(input int cnt, input string req);
    @(negedge rclk); rd_en_a_n = 0; rd_en_b_n = 0;
    for (int i = 0; i < cnt; i++) begin
      expq.push_back(slot_val(msel));
      while (!rd_ready) @(negedge rclk);
      @(negedge rclk);
      msel = (msel + 1) % 4;
      check(rd_ready == 0, {req, " R8 ready low after accept"}, 32'(rd_ready), 0);
    end
    rd_en_a_n = 1; rd_en_b_n = 1;
    repeat (10) @(negedge rclk);
  endtask

  task automatic open_session();  @(negedge wclk); load_n = 0; repeat (2) @(negedge wclk); endtask
  task automatic close_session(); @(negedge wclk); load_n = 1; repeat (8) @(negedge wclk); endtask

  // monitor: scoreboard compare
  always @(negedge rclk) begin
    if (rst_n && rd_data_valid) begin
      if (expq.size() == 0) check(0, "R1/R5 unexpected read data", 32'(rd_data), 0);
      else begin
        automatic logic [DATA_W-1:0] e = expq.pop_front();
        check(rd_data == e, "R5 readback", 32'(rd_data), 32'(e));
      end
    end
  end

  initial begin
    #(20 * 150000);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset(1'b0); // programmable mode
    check(n_ofs == 15'd7 && m_ofs == 15'd7, "R2 reset offsets", 32'(n_ofs), 7);
    check(rd_data == 0 && rd_data_valid == 0, "R2 reset read data", 32'(rd_data), 0);
    check(rd_ready == 1, "R2 reset ready", 32'(rd_ready), 1);

    open_session();
    check(wr_hold == 1 && rd_hold == 1, "R9 holds during load", {wr_hold, rd_hold}, 3);
    read_burst(4, "R2 defaults readback");
    close_session();
    check(wr_hold == 0 && rd_hold == 0, "R9 holds released", {wr_hold, rd_hold}, 0);

    open_session();
    write_byte(8'h25); write_byte(8'hFF);
    close_session();
    check(n_ofs == exp_n(), "R3 R6 R7 empty threshold", 32'(n_ofs), 32'(exp_n()));
    check(n_ofs == 15'h7F25, "R6 upper bits ignored", 32'(n_ofs), 32'h7F25);
    check(m_ofs == 15'd7, "R10 full threshold untouched", 32'(m_ofs), 7);

    open_session(); write_byte(8'h30); close_session();
    check(m_ofs == 15'h0030, "R4 session continues at full low", 32'(m_ofs), 32'h30);

    open_session(); write_byte(8'hC3); write_byte(8'h11); close_session();
    check(m_ofs == 15'h4330, "R3 full high", 32'(m_ofs), 32'h4330);
    check(n_ofs == 15'h7F11, "R3 wrap to empty low", 32'(n_ofs), 32'h7F11);

    open_session(); read_burst(5, "R4 R5 R6 wrap readback"); close_session();
    open_session(); read_burst(1, "R4 read session continues"); close_session();
    open_session(); write_byte(8'h05); close_session();
    check(m_ofs == 15'h0530, "R4 reads moved shared pointer", 32'(m_ofs), 32'h0530);

    do_reset(1'b1); // plain mode
    check(n_ofs == 15'd7 && m_ofs == 15'd7, "R2 reset restores defaults", 32'(m_ofs), 7);
    @(negedge wclk); load_n = 0; wr_en_n = 0; wr_data = 8'hAA; rd_en_a_n = 0; rd_en_b_n = 0;
    repeat (10) @(negedge wclk);
    check(n_ofs == 15'd7 && m_ofs == 15'd7, "R1 plain mode ignores stores", 32'(n_ofs), 7);
    check(wr_hold == 0 && rd_hold == 0, "R1 plain mode no holds", {wr_hold, rd_hold}, 0);
    check(rd_data == 0, "R1 plain mode no readback", 32'(rd_data), 0);
    wr_en_n = 1; rd_en_a_n = 1; rd_en_b_n = 1; load_n = 1;

    do_reset(1'b0);
    open_session(); write_byte(8'h44); close_session();
    check(n_ofs == 15'h0044, "R2 pointer back at slot 0", 32'(n_ofs), 32'h44);
    check(expq.size() == 0, "R5 all reads returned", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule